// File: doc/BRIEF.md
# Reset Sequencer with Completion Interrupt

This block controls how a register-based device with an embedded processing engine gets back to a known state. Three events can start a reset: the external reset pin, entry into the active power mode, and a software request bit in a 16-bit control word. The block tells the register file what to restore through two strobes. `dflt_all_o` restores the ordinary registers. `dflt_kept_o` restores the small group of configuration bytes, which only a full reset touches.

Each reset runs through a transition of a fixed, parameterised length. When the transition ends, the block raises a completion flag and pulls an active-low interrupt pin low. The flag cannot be masked, and software clears it by writing a one to bit 15 of a 32-bit status word. After any reset the processing engine stays idle. It starts only when the start word 0x0001 is written to a 16-bit run register.

The external reset pin and the software request only act in the active power mode. In the low-power mode both are ignored.

Top module: `reset_sequencer`

## Requirements
- R1: In the active mode (`pwr_active`=1), holding `rst_pin_n` low holds both strobes high for as long as the pin stays low. Releasing the pin then runs a transition of RST_CYCLES cycles, after which the completion flag is set. The pin passes through a two-stage synchronizer first.
- R2: In the low-power mode (`pwr_active`=0), `rst_pin_n` has no effect: no strobe rises and the completion flag does not change.
- R3: A rising edge of `pwr_active` runs a full reset, with both `dflt_all_o` and `dflt_kept_o` high. This includes `pwr_active` being high on the first clock after system reset.
- R4: A control write with bit 7 set (the software-reset bit), made in the active mode while no reset is running, starts a software reset. During it `dflt_all_o` is high, `dflt_kept_o` stays low and `swrst_o` reads 1. `swrst_o` returns to 0 when the transition ends.
- R5: A control write is ignored in three cases: bit 7 is 0, the block is in the low-power mode, or a reset is already running.
- R6: Every transition holds `dflt_all_o` high for exactly RST_CYCLES cycles after its last trigger, and `rst_done_o` reads 0 throughout. In the cycle the transition ends, `rst_done_o` becomes 1 and `irq_n_o` goes low.
- R7: A status write with bit 15 set clears `rst_done_o` and returns `irq_n_o` high. A status write with bit 15 clear leaves both unchanged, whatever its other bits are.
- R8: Any reset stops the engine, so `engine_run_o`=0. Only a run-register write of exactly 0x0001 made while no reset is running sets `engine_run_o`. A write of any other value clears it, and run writes made during a reset are ignored.
- R9: Driving the pin low in the active mode during a software reset turns it into a full reset, and `dflt_kept_o` rises.
- R10: While `rst_n` is low, every strobe, `swrst_o`, `rst_done_o` and `engine_run_o` read 0 and `irq_n_o` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| rst_pin_n | input | 1 | External active-low reset pin (asynchronous, synchronized inside) |
| pwr_active | input | 1 | 1 = active power mode, 0 = low-power mode |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | CTRL_W | Control write data; bit SWRST_BIT requests a software reset |
| stat_wr | input | 1 | Write strobe for the status word |
| stat_wdata | input | STAT_W | Status write data; a one in bit DONE_BIT clears the completion flag |
| run_wr | input | 1 | Write strobe for the run register |
| run_wdata | input | RUN_W | Run register write data |
| dflt_all_o | output | 1 | Restore defaults in the ordinary registers |
| dflt_kept_o | output | 1 | Restore defaults in the configuration bytes kept by a software reset |
| swrst_o | output | 1 | Read-back of the self-clearing software-reset bit |
| rst_done_o | output | 1 | Completion flag (status bit 15) |
| irq_n_o | output | 1 | Active-low completion interrupt |
| engine_run_o | output | 1 | Processing engine enabled |

## Verification
The bench targets the ways the reset kinds interact. A software request or a pin pulse in the low-power mode must leave every output quiet; a design that skipped this gating would raise the strobes. A pin pulse during a software reset must raise `dflt_kept_o`; a design that ignored it would leave the configuration bytes stale. The end of each transition is sampled on the exact cycle, so a counter that is off by one shows up as an early or late completion flag. The bench also writes status words with bit 15 clear but other bits set, run words close to the start value, and run writes during a reset; a loose write-one-to-clear or a loose start decode would then clear the flag or start the engine.

// File: rtl/rseq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: only the reset sequencer and its submodules import this package.
package rseq_pkg;

    // Sequencer phase: quiet, pin held low, or timed transition.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_XFER = 2'd2
    } rseq_state_e;

    // Scope of the reset in progress.
    typedef enum logic {
        KIND_SOFT = 1'b0,
        KIND_FULL = 1'b1
    } rseq_kind_e;

endpackage

// File: rtl/rseq_pin_sync.sv
// Brings the asynchronous external reset pin into the clock domain.
// Assumes: the pin idles high; STAGES >= 1; the output resets to 1.
module rseq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_s
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= pin_n;
            end
        end else begin : g_multi
            // Shift register of capture flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign pin_s = chain[STAGES-1];

endmodule

// File: rtl/rseq_fsm.sv
// Decides which reset runs and for how long, and drives the default strobes.
// Assumes: pin_s is already synchronous; sw_req is a one-cycle write qualifier.
// A full reset overrides a running software reset; the counter reloads on
// every new trigger so the transition always lasts RST_CYCLES cycles.
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int RST_CYCLES = 8,
    localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_s,
    input  logic        pwr_active,
    input  logic        sw_req,
    output rseq_state_e state,
    output logic        busy,
    output logic        busy_nxt,
    output logic        fin,
    output logic        dflt_all,
    output logic        dflt_kept,
    output logic        swrst
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    rseq_state_e      state_n;
    rseq_kind_e       kind, kind_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             pwr_q;
    logic             pwr_rise;
    logic             hw_low;

    assign pwr_rise = pwr_active && !pwr_q;
    assign hw_low   = pwr_active && !pin_s;

    // Remember the previous power mode to detect entry into the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= pwr_active;
    end

    // Next-state selection with priority: pin, power entry, software request.
    always_comb begin
        state_n = state;
        kind_n  = kind;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (hw_low) begin
                    state_n = ST_HOLD;
                    kind_n  = KIND_FULL;
                end else if (pwr_rise) begin
                    state_n = ST_XFER;
                    kind_n  = KIND_FULL;
                    cnt_n   = CNT_LOAD;
                end else if (sw_req && pwr_active) begin
                    state_n = ST_XFER;
                    kind_n  = KIND_SOFT;
                    cnt_n   = CNT_LOAD;
                end
            end
            ST_HOLD: begin
                if (pin_s) begin
                    state_n = ST_XFER;
                    kind_n  = KIND_FULL;
                    cnt_n   = CNT_LOAD;
                end
            end
            ST_XFER: begin
                if (hw_low) begin
                    state_n = ST_HOLD;
                    kind_n  = KIND_FULL;
                end else if (pwr_rise) begin
                    kind_n  = KIND_FULL;
                    cnt_n   = CNT_LOAD;
                end else if (cnt == '0) begin
                    state_n = ST_IDLE;
                end else begin
                    cnt_n   = cnt - 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                kind_n  = KIND_SOFT;
            end
        endcase
    end

    // State, kind and countdown registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            kind  <= KIND_SOFT;
            cnt   <= '0;
        end else begin
            state <= state_n;
            kind  <= kind_n;
            cnt   <= cnt_n;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign busy_nxt  = (state_n != ST_IDLE);
    assign fin       = (state == ST_XFER) && (state_n == ST_IDLE);
    assign dflt_all  = busy;
    assign dflt_kept = busy && (kind == KIND_FULL);
    assign swrst     = (state == ST_XFER) && (kind == KIND_SOFT);

    assert_lowpwr_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !pwr_active) |=> (state != ST_HOLD));

    assert_pin_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && pin_s) |=> (state == ST_XFER && cnt == CNT_LOAD));

    assert_xfer_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_XFER) |-> ($past(cnt) == '0));

    assert_soft_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pwr_active && pin_s && !pwr_rise && sw_req)
            |=> (dflt_all && !dflt_kept && swrst));

    assert_escalate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (swrst && hw_low) |=> (dflt_kept && state == ST_HOLD));

endmodule

// File: rtl/rseq_done_irq.sv
// Completion flag (write-one-to-clear, unmaskable) and the active-low interrupt.
// Assumes: fin pulses for one cycle at the end of a transition and busy_nxt
// is high whenever a reset is running or about to start.
module rseq_done_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fin,
    input  logic busy,
    input  logic busy_nxt,
    input  logic clr_req,
    output logic rst_done,
    output logic irq_n
);

    logic done_n;

    // Completion beats a clear in the same cycle; a running reset keeps the flag low.
    always_comb begin
        if (fin)           done_n = 1'b1;
        else if (busy_nxt) done_n = 1'b0;
        else if (clr_req)  done_n = 1'b0;
        else               done_n = rst_done;
    end

    // Flag and interrupt pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_done <= 1'b0;
            irq_n    <= 1'b1;
        end else begin
            rst_done <= done_n;
            irq_n    <= !done_n;
        end
    end

    assert_done_low_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rst_done);

    assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_done) |-> $past(fin));

    assert_w1c_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && !clr_req && !busy_nxt) |=> rst_done);

    assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_done) |-> $fell(irq_n));

endmodule

// File: rtl/rseq_engine_gate.sv
// Holds the processing engine idle across resets until the start word is written.
// Assumes: busy and busy_nxt come from the sequencer state machine.
module rseq_engine_gate #(
    parameter int                 RUN_W     = 16,
    parameter logic [RUN_W-1:0]   RUN_START = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             busy_nxt,
    input  logic             run_wr,
    input  logic [RUN_W-1:0] run_wdata,
    output logic             run
);

    logic wr_ok;

    assign wr_ok = run_wr && !busy && !busy_nxt;

    // Engine enable: cleared by any reset, loaded only outside a reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               run <= 1'b0;
        else if (busy || busy_nxt) run <= 1'b0;
        else if (wr_ok)           run <= (run_wdata == RUN_START);
    end

    assert_run_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(run_wr && run_wdata == RUN_START));

    assert_idle_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !run);

endmodule

// File: rtl/reset_sequencer.sv
// Top of the reset sequencer: pin synchronizer, state machine, completion
// flag and engine gate. Assumes all write strobes are one-cycle and synchronous.
module reset_sequencer
    import rseq_pkg::*;
#(
    parameter int RST_CYCLES  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_W      = 16,
    parameter int STAT_W      = 32,
    parameter int RUN_W       = 16,
    parameter int SWRST_BIT   = 7,
    parameter int DONE_BIT    = 15,
    parameter int RUN_START   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin_n,
    input  logic              pwr_active,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              run_wr,
    input  logic [RUN_W-1:0]  run_wdata,
    output logic              dflt_all_o,
    output logic              dflt_kept_o,
    output logic              swrst_o,
    output logic              rst_done_o,
    output logic              irq_n_o,
    output logic              engine_run_o
);

    localparam logic [RUN_W-1:0] START_WORD = RUN_W'(RUN_START);

    logic        pin_s;
    logic        sw_req;
    logic        clr_req;
    logic        busy, busy_nxt, fin;
    rseq_state_e state;
    logic        unused_bits;

    assign sw_req      = ctrl_wr && ctrl_wdata[SWRST_BIT];
    assign clr_req     = stat_wr && stat_wdata[DONE_BIT];
    assign unused_bits = ^{ctrl_wdata, stat_wdata, state};

    rseq_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (rst_pin_n),
        .pin_s (pin_s)
    );

    rseq_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (pin_s),
        .pwr_active (pwr_active),
        .sw_req     (sw_req),
        .state      (state),
        .busy       (busy),
        .busy_nxt   (busy_nxt),
        .fin        (fin),
        .dflt_all   (dflt_all_o),
        .dflt_kept  (dflt_kept_o),
        .swrst      (swrst_o)
    );

    rseq_done_irq i_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin),
        .busy     (busy),
        .busy_nxt (busy_nxt),
        .clr_req  (clr_req),
        .rst_done (rst_done_o),
        .irq_n    (irq_n_o)
    );

    rseq_engine_gate #(
        .RUN_W     (RUN_W),
        .RUN_START (START_WORD)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .busy_nxt  (busy_nxt),
        .run_wr    (run_wr),
        .run_wdata (run_wdata),
        .run       (engine_run_o)
    );

    assert_kept_in_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_kept_o |-> dflt_all_o);

    assert_lowpwr_sw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pwr_active && ctrl_wr) |=> !swrst_o);

endmodule

// File: tb/test_reset_sequencer.sv
// Self-checking bench for reset_sequencer: vector table, then directed tests.
module test_reset_sequencer;

    localparam int C = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic        pwr_active = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        stat_wr = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic        run_wr = 1'b0;
    logic [15:0] run_wdata = '0;
    logic        dflt_all_o, dflt_kept_o, swrst_o, rst_done_o, irq_n_o, engine_run_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Vector layout: {op[1:0] (1 = status write, 2 = run write), data[31:0], exp_run, exp_done}
    localparam logic [35:0] VEC [0:8] = '{
        {2'd1, 32'h0000_7FFF, 1'b0, 1'b1},
        {2'd2, 32'h0000_0002, 1'b0, 1'b1},
        {2'd2, 32'h0000_0101, 1'b0, 1'b1},
        {2'd2, 32'h0000_0001, 1'b1, 1'b1},
        {2'd1, 32'hFFFF_7FFF, 1'b1, 1'b1},
        {2'd2, 32'h0000_0000, 1'b0, 1'b1},
        {2'd2, 32'h0000_0001, 1'b1, 1'b1},
        {2'd1, 32'h0000_8000, 1'b1, 1'b0},
        {2'd1, 32'h0000_8000, 1'b1, 1'b0}
    };

    reset_sequencer #(.RST_CYCLES(C)) i_reset_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_pin_n    (rst_pin_n),
        .pwr_active   (pwr_active),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .stat_wr      (stat_wr),
        .stat_wdata   (stat_wdata),
        .run_wr       (run_wr),
        .run_wdata    (run_wdata),
        .dflt_all_o   (dflt_all_o),
        .dflt_kept_o  (dflt_kept_o),
        .swrst_o      (swrst_o),
        .rst_done_o   (rst_done_o),
        .irq_n_o      (irq_n_o),
        .engine_run_o (engine_run_o)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [15:0] d);
        ctrl_wr = 1'b1; ctrl_wdata = d;
        step();
        ctrl_wr = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic stat_write(input logic [31:0] d);
        stat_wr = 1'b1; stat_wdata = d;
        step();
        stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic run_write(input logic [15:0] d);
        run_wr = 1'b1; run_wdata = d;
        step();
        run_wr = 1'b0; run_wdata = '0;
    endtask

    initial begin
        @(negedge clk);
        step(3);
        // R10: quiet outputs under system reset
        check("R10 all", {31'd0, dflt_all_o}, 32'd0);
        check("R10 kept", {31'd0, dflt_kept_o}, 32'd0);
        check("R10 irq_n", {31'd0, irq_n_o}, 32'd1);
        check("R10 done", {31'd0, rst_done_o}, 32'd0);
        check("R10 run", {31'd0, engine_run_o}, 32'd0);
        rst_n = 1'b1;
        step(2);
        check("R10 quiet after release in low power", {31'd0, dflt_all_o}, 32'd0);

        // R3: entry into active mode runs a full reset
        pwr_active = 1'b1;
        step();
        check("R3 all", {31'd0, dflt_all_o}, 32'd1);
        check("R3 kept", {31'd0, dflt_kept_o}, 32'd1);
        check("R6 done low while busy", {31'd0, rst_done_o}, 32'd0);
        step(C - 1);
        check("R6 still busy at last cycle", {31'd0, dflt_all_o}, 32'd1);
        step();
        check("R6 strobe ends", {31'd0, dflt_all_o}, 32'd0);
        check("R6 done set", {31'd0, rst_done_o}, 32'd1);
        check("R6 irq low", {31'd0, irq_n_o}, 32'd0);

        // R7, R8: vector table of status and run writes
        for (int v = 0; v < 9; v++) begin
            if (VEC[v][35:34] == 2'd1) stat_write(VEC[v][33:2]);
            else                       run_write(VEC[v][17:2]);
            check("R8 vector run", {31'd0, engine_run_o}, {31'd0, VEC[v][1]});
            check("R7 vector done", {31'd0, rst_done_o}, {31'd0, VEC[v][0]});
            check("R7 vector irq", {31'd0, irq_n_o}, {31'd0, ~VEC[v][0]});
        end

        // R4, R8: software reset keeps configuration bytes, stops the engine
        ctrl_write(16'h0080);
        check("R4 all", {31'd0, dflt_all_o}, 32'd1);
        check("R4 kept low", {31'd0, dflt_kept_o}, 32'd0);
        check("R4 swrst reads 1", {31'd0, swrst_o}, 32'd1);
        check("R8 engine stopped", {31'd0, engine_run_o}, 32'd0);
        step(C);
        check("R4 swrst self-clears", {31'd0, swrst_o}, 32'd0);
        check("R4 done", {31'd0, rst_done_o}, 32'd1);

        // R5, R2: low-power mode ignores software request and pin
        pwr_active = 1'b0;
        step();
        stat_write(32'h0000_8000);
        ctrl_write(16'h0080);
        step();
        check("R5 sw ignored in low power", {30'd0, dflt_all_o, swrst_o}, 32'd0);
        rst_pin_n = 1'b0;
        step(5);
        check("R2 pin ignored", {30'd0, dflt_all_o, dflt_kept_o}, 32'd0);
        rst_pin_n = 1'b1;
        step(5);
        check("R2 no done", {31'd0, rst_done_o}, 32'd0);

        // Back to active mode, then a control write without bit 7 (R5)
        pwr_active = 1'b1;
        step(C + 1);
        check("R3 reentry done", {31'd0, rst_done_o}, 32'd1);
        stat_write(32'h0000_8000);
        ctrl_write(16'hFF7F);
        step();
        check("R5 bit7 clear ignored", {31'd0, dflt_all_o}, 32'd0);

        // R1: hardware pin reset in active mode
        rst_pin_n = 1'b0;
        step(3);
        check("R1 hold all", {31'd0, dflt_all_o}, 32'd1);
        check("R1 hold kept", {31'd0, dflt_kept_o}, 32'd1);
        step(10);
        check("R1 still held", {30'd0, dflt_all_o, rst_done_o}, 32'd2);
        rst_pin_n = 1'b1;
        step(3 + C - 1);
        check("R1 transition last cycle", {31'd0, dflt_all_o}, 32'd1);
        step();
        check("R1 done", {31'd0, rst_done_o}, 32'd1);
        check("R1 irq", {31'd0, irq_n_o}, 32'd0);

        // R9: pin during software reset escalates to full
        stat_write(32'h0000_8000);
        ctrl_write(16'h0080);
        check("R9 soft first", {31'd0, dflt_kept_o}, 32'd0);
        rst_pin_n = 1'b0;
        step(3);
        check("R9 escalated", {31'd0, dflt_kept_o}, 32'd1);
        rst_pin_n = 1'b1;
        step(3 + C);
        check("R9 done", {31'd0, rst_done_o}, 32'd1);

        // R8: run write during a reset is ignored
        stat_write(32'h0000_8000);
        ctrl_write(16'h0080);
        run_write(16'h0001);
        check("R8 run ignored while busy", {31'd0, engine_run_o}, 32'd0);
        step(C - 1);
        check("R8 engine idle after reset", {30'd0, engine_run_o, rst_done_o}, 32'd1);
        run_write(16'h0001);
        check("R8 start after reset", {31'd0, engine_run_o}, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule